// File: doc/BRIEF.md
# DLL Bring-up Sequencer

This block steps a group of delay-locked loops through their power-up sequence. The group has one master DLL and several byte-lane slave DLLs. A single start pulse begins a run. In the same clock edge, the block loads a phase setting into every DLL it targets, then walks those DLLs through three control states:

- held disabled and in reset;
- enabled but still in reset;
- running.

Each state is held for a fixed number of microsecond ticks. The block has no timebase of its own: a free-running one-cycle tick pulse supplies it.

A mode input chooses what a run targets. In one mode the run brings up the master DLL alone. In the other mode it brings up the slave lanes, and the bus-width input sets how many lanes are active. A 16-bit bus drives two lanes and a 32-bit bus drives four. All targeted lanes change state in the same clock cycle.

A 32-bit phase word supplies the settings:
- The master phase is the 6-bit field at bits 21:16.
- Each slave lane takes a 4-bit nibble from the low half-word, starting at bit 0.

DLLs that a run does not target keep their state. A done pulse marks the end of the run. Done and busy are the only status outputs.

Top module: `dll_bringup_seq`

## Requirements
- R1: While rst_ni is low, every bit of dll_disable_o is 1, every bit of dll_nreset_o is 0, all phase outputs are 0, and busy_o and done_o are 0.
- R2: A start_i sampled high while idle with slave_mode_i=0 targets the master only (index 0 of the control vectors). After that edge, busy_o=1, mst_phase_o equals phase_word_i[21:16], dll_disable_o[0]=1 and dll_nreset_o[0]=0.
- R3: A start_i sampled high while idle with slave_mode_i=1 targets the slave lanes. With wide_bus_i=1 these are lanes 1 to 4; with wide_bus_i=0 they are lanes 1 and 2. Lane k (control index k) loads phase_word_i[4k-1:4k-4] into slv_phase_o[4k-1:4k-4], and its disable goes to 1 and its nreset to 0.
- R4: On the edge that samples the second tick_us_i pulse after the load, disable falls for every targeted DLL while nreset stays low. The first pulse changes nothing.
- R5: On the edge that samples the 22nd tick pulse after step 2, nreset rises for every targeted DLL, with disable low. The 21st pulse changes nothing.
- R6: On the edge that samples the 22nd tick pulse after step 3, done_o goes high for exactly one cycle and busy_o falls in that same cycle.
- R7: DLLs not targeted by a run keep their phase, disable and nreset values for the whole run. All targeted DLLs change in the same cycle.
- R8: A start_i pulse while busy_o=1 has no effect on the run, its target set or its timing.
- R9: The phase word is sampled only in the start cycle. Later changes to it during a run do not alter any phase output.
- R10: No DLL ever has disable and nreset high at the same time.
- R11: Only cycles with tick_us_i=1 advance the waits. Tick pulses while idle change no output.
- R12: Asserting rst_ni in the middle of a run immediately returns all outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a run when idle |
| phase_word_i | input | 32 | Packed phase settings |
| wide_bus_i | input | 1 | 1 = 32-bit bus (4 lanes), 0 = 16-bit bus (2 lanes) |
| slave_mode_i | input | 1 | 0 = run the master DLL, 1 = run the slave lanes |
| tick_us_i | input | 1 | One-cycle pulse each microsecond |
| mst_phase_o | output | 6 | Master DLL phase |
| slv_phase_o | output | 16 | Slave lane phases, lane k at bits 4k-1:4k-4 |
| dll_disable_o | output | 5 | Disable per DLL, index 0 is the master |
| dll_nreset_o | output | 5 | Active-low reset per DLL, index 0 is the master |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |

## Verification
The assertions check the following on every cycle:
- disable and nreset are never high together for any DLL;
- a disable bit only falls while that DLL's reset is held;
- a reset bit only rises on a DLL that is already enabled;
- phases stay frozen while a run is in progress;
- done is a single-cycle pulse that coincides with idle.

Some behaviour can only be shown by the bench's scenarios. These are the exact tick counts of 2, 22 and 22, the nibble-to-lane mapping under each bus width, and untargeted lanes keeping their values from an earlier run. The bench also covers a start that arrives during a run, the phase word changing during a run, and a reset in the middle of a run.

// File: rtl/dll_seq_pkg.sv
package dll_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_RST,
    ST_WAIT_EN,
    ST_WAIT_RUN
  } seq_st_e;

  typedef enum logic [1:0] {
    OP_HOLD,
    OP_LOAD,
    OP_ENABLE,
    OP_RELEASE
  } dll_op_e;
endpackage

// File: rtl/dll_us_timer.sv
module dll_us_timer #(
  parameter int SHORT_US = 2,
  parameter int LONG_US  = 22,
  parameter int CNT_W    = $clog2(LONG_US + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic long_i,
  input  logic tick_i,
  output logic expired_o
);
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_US - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_US - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = tick_i && (cnt_q == (long_i ? LONG_LAST : SHORT_LAST));
endmodule

// File: rtl/dll_lane_map.sv
module dll_lane_map #(
  parameter int WORD_W  = 32,
  parameter int N_SLV   = 4,
  parameter int NIB_W   = 4,
  parameter int MPH_W   = 6,
  parameter int MPH_LSB = 16,
  localparam int N_DLL  = N_SLV + 1,
  localparam int N_NARROW = N_SLV / 2
) (
  input  logic [WORD_W-1:0]      word_i,
  input  logic                   wide_i,
  input  logic                   slave_mode_i,
  output logic [MPH_W-1:0]       mst_phase_o,
  output logic [N_SLV*NIB_W-1:0] slv_phase_o,
  output logic [N_DLL-1:0]       tgt_o
);
  logic unused_word_bits;
  assign unused_word_bits = ^word_i;

  assign mst_phase_o = word_i[MPH_LSB +: MPH_W];
  assign tgt_o[0]    = !slave_mode_i;

  for (genvar k = 0; k < N_SLV; k++) begin : g_lane
    assign slv_phase_o[k*NIB_W +: NIB_W] = word_i[k*NIB_W +: NIB_W];
    if (k < N_NARROW) begin : g_always
      assign tgt_o[k+1] = slave_mode_i;
    end else begin : g_wide_only
      assign tgt_o[k+1] = slave_mode_i && wide_i;
    end
  end
endmodule

// File: rtl/dll_channel.sv
module dll_channel
  import dll_seq_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sel_i,
  input  dll_op_e         op_i,
  input  logic [PH_W-1:0] phase_i,
  output logic [PH_W-1:0] phase_o,
  output logic            disable_o,
  output logic            nreset_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o   <= '0;
      disable_o <= 1'b1;
      nreset_o  <= 1'b0;
    end else if (sel_i) begin
      unique case (op_i)
        OP_LOAD: begin
          phase_o   <= phase_i;
          disable_o <= 1'b1;
          nreset_o  <= 1'b0;
        end
        OP_ENABLE: disable_o <= 1'b0;
        OP_RELEASE: begin
          disable_o <= 1'b0;
          nreset_o  <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dll_bringup_seq.sv
module dll_bringup_seq
  import dll_seq_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int N_SLV    = 4,
  parameter int NIB_W    = 4,
  parameter int MPH_W    = 6,
  parameter int MPH_LSB  = 16,
  parameter int SHORT_US = 2,
  parameter int LONG_US  = 22,
  localparam int N_DLL   = N_SLV + 1,
  localparam int CNT_W   = $clog2(LONG_US + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [WORD_W-1:0]      phase_word_i,
  input  logic                   wide_bus_i,
  input  logic                   slave_mode_i,
  input  logic                   tick_us_i,
  output logic [MPH_W-1:0]       mst_phase_o,
  output logic [N_SLV*NIB_W-1:0] slv_phase_o,
  output logic [N_DLL-1:0]       dll_disable_o,
  output logic [N_DLL-1:0]       dll_nreset_o,
  output logic                   busy_o,
  output logic                   done_o
);
  seq_st_e                state_q, state_d;
  logic [N_DLL-1:0]       tgt_q, tgt_now, sel;
  logic [MPH_W-1:0]       mst_ph_in;
  logic [N_SLV*NIB_W-1:0] slv_ph_in;
  logic                   start_ok, expired, done_q;
  dll_op_e                op;

  dll_lane_map #(
    .WORD_W (WORD_W),
    .N_SLV  (N_SLV),
    .NIB_W  (NIB_W),
    .MPH_W  (MPH_W),
    .MPH_LSB(MPH_LSB)
  ) u_map (
    .word_i      (phase_word_i),
    .wide_i      (wide_bus_i),
    .slave_mode_i(slave_mode_i),
    .mst_phase_o (mst_ph_in),
    .slv_phase_o (slv_ph_in),
    .tgt_o       (tgt_now)
  );

  assign start_ok = start_i && (state_q == ST_IDLE);

  dll_us_timer #(
    .SHORT_US(SHORT_US),
    .LONG_US (LONG_US),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (start_ok || expired || (state_q == ST_IDLE)),
    .long_i   (state_q != ST_WAIT_RST),
    .tick_i   (tick_us_i),
    .expired_o(expired)
  );

  always_comb begin
    state_d = state_q;
    op      = OP_HOLD;
    if (start_ok) begin
      op      = OP_LOAD;
      state_d = ST_WAIT_RST;
    end else if (expired) begin
      unique case (state_q)
        ST_WAIT_RST: begin op = OP_ENABLE;  state_d = ST_WAIT_EN;  end
        ST_WAIT_EN:  begin op = OP_RELEASE; state_d = ST_WAIT_RUN; end
        ST_WAIT_RUN: state_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  assign sel = start_ok ? tgt_now : tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= expired && (state_q == ST_WAIT_RUN);
      if (start_ok) tgt_q <= tgt_now;
    end
  end

  dll_channel #(.PH_W(MPH_W)) u_mst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel[0]),
    .op_i     (op),
    .phase_i  (mst_ph_in),
    .phase_o  (mst_phase_o),
    .disable_o(dll_disable_o[0]),
    .nreset_o (dll_nreset_o[0])
  );

  for (genvar k = 0; k < N_SLV; k++) begin : g_slv
    dll_channel #(.PH_W(NIB_W)) u_slv (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .sel_i    (sel[k+1]),
      .op_i     (op),
      .phase_i  (slv_ph_in[k*NIB_W +: NIB_W]),
      .phase_o  (slv_phase_o[k*NIB_W +: NIB_W]),
      .disable_o(dll_disable_o[k+1]),
      .nreset_o (dll_nreset_o[k+1])
    );
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/dll_bringup_seq_chk.sv
module dll_bringup_seq_chk #(
  parameter int N_DLL = 5,
  parameter int PH_W  = 16,
  parameter int MPH_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [N_DLL-1:0] dll_disable_o,
  input logic [N_DLL-1:0] dll_nreset_o,
  input logic [MPH_W-1:0] mst_phase_o,
  input logic [PH_W-1:0]  slv_phase_o
);
  a_r10_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dll_disable_o & dll_nreset_o) == '0);

  a_r4_enable_keeps_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(dll_disable_o) & ~dll_disable_o & dll_nreset_o) == '0);

  a_r5_release_only_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~$past(dll_nreset_o) & dll_nreset_o & $past(dll_disable_o)) == '0);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r2_busy_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  a_r9_phase_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(mst_phase_o) && $stable(slv_phase_o)));
endmodule

bind dll_bringup_seq dll_bringup_seq_chk #(
  .N_DLL(N_DLL),
  .PH_W (N_SLV*NIB_W),
  .MPH_W(MPH_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .dll_disable_o(dll_disable_o),
  .dll_nreset_o (dll_nreset_o),
  .mst_phase_o  (mst_phase_o),
  .slv_phase_o  (slv_phase_o)
);

// File: tb/dll_bringup_seq_test.sv
module dll_bringup_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] phase_word_i = '0;
  logic        wide_bus_i = 1'b0;
  logic        slave_mode_i = 1'b0;
  logic        tick_us_i = 1'b0;
  logic [5:0]  mst_phase_o;
  logic [15:0] slv_phase_o;
  logic [4:0]  dll_disable_o, dll_nreset_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [5:0]  e_mst;
  logic [15:0] e_slv;
  logic [4:0]  e_dis, e_nr, e_tgt;
  logic        e_busy, e_done;

  // {slave_mode, wide_bus, phase_word}
  localparam logic [33:0] VEC [7] = '{
    {1'b0, 1'b0, 32'h003F_0000},
    {1'b0, 1'b1, 32'hFFC0_FFFF},
    {1'b1, 1'b0, 32'h0000_00A5},
    {1'b1, 1'b1, 32'h0000_4321},
    {1'b1, 1'b1, 32'hFFFF_ABCD},
    {1'b1, 1'b0, 32'h1234_5678},
    {1'b0, 1'b1, 32'h0015_0000}
  };

  always #2 clk_i = ~clk_i;

  dll_bringup_seq uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .phase_word_i (phase_word_i),
    .wide_bus_i   (wide_bus_i),
    .slave_mode_i (slave_mode_i),
    .tick_us_i    (tick_us_i),
    .mst_phase_o  (mst_phase_o),
    .slv_phase_o  (slv_phase_o),
    .dll_disable_o(dll_disable_o),
    .dll_nreset_o (dll_nreset_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp_v);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "mst_phase", 32'(mst_phase_o), 32'(e_mst));
    chk(req, "slv_phase", 32'(slv_phase_o), 32'(e_slv));
    chk(req, "disable",   32'(dll_disable_o), 32'(e_dis));
    chk(req, "nreset",    32'(dll_nreset_o), 32'(e_nr));
    chk(req, "busy",      32'(busy_o), 32'(e_busy));
    chk(req, "done",      32'(done_o), 32'(e_done));
  endtask

  task automatic model_reset();
    e_mst = '0; e_slv = '0; e_dis = '1; e_nr = '0; e_busy = 0; e_done = 0; e_tgt = '0;
  endtask

  task automatic cyc();
    @(posedge clk_i); #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_us_i = 1'b1; cyc();
      tick_us_i = 1'b0; cyc();
    end
  endtask

  task automatic run_seq(input logic mode, input logic wide, input logic [31:0] word, input bit disturb);
    slave_mode_i = mode; wide_bus_i = wide; phase_word_i = word; start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    e_tgt = !mode ? 5'b00001 : (wide ? 5'b11110 : 5'b00110);
    if (e_tgt[0]) e_mst = word[21:16];
    for (int k = 1; k < 5; k++)
      if (e_tgt[k]) e_slv[(k-1)*4 +: 4] = word[(k-1)*4 +: 4];
    e_dis |= e_tgt; e_nr &= ~e_tgt; e_busy = 1;
    check_all(mode ? "R3/R7" : "R2/R7");
    ticks(1);
    check_all("R4/R11");
    ticks(1);
    e_dis &= ~e_tgt;
    check_all("R4/R10");
    ticks(10);
    if (disturb) begin
      phase_word_i = ~word; slave_mode_i = ~mode; wide_bus_i = ~wide; start_i = 1'b1;
      cyc();
      start_i = 1'b0;
      check_all("R8/R9");
    end
    ticks(11);
    check_all("R5");
    ticks(1);
    e_nr |= e_tgt;
    check_all("R5/R7");
    ticks(21);
    check_all("R6");
    tick_us_i = 1'b1; cyc(); tick_us_i = 1'b0;
    e_busy = 0; e_done = 1;
    check_all("R6");
    cyc();
    e_done = 0;
    check_all("R6");
  endtask

  initial begin
    model_reset();
    cyc(); cyc();
    check_all("R1");
    rst_ni = 1'b1;
    cyc();
    check_all("R1");

    // idle ticks must not move anything
    ticks(30);
    check_all("R11");

    for (int i = 0; i < 7; i++)
      run_seq(VEC[i][33], VEC[i][32], VEC[i][31:0], i == 2);

    // reset in the middle of a run
    slave_mode_i = 1'b1; wide_bus_i = 1'b1; phase_word_i = 32'h0000_9999; start_i = 1'b1;
    cyc();
    start_i = 1'b0;
    ticks(3);
    rst_ni = 1'b0;
    #1;
    model_reset();
    check_all("R12");
    cyc();
    rst_ni = 1'b1;
    cyc();
    check_all("R12");

    run_seq(1'b1, 1'b0, 32'h0000_0021, 1'b0);

    finish_run();
  end
endmodule